// File: doc/BRIEF.md
# Collective Tree Reduce-Broadcast Node

This block is one router node of a tree-shaped collective network. It has up to three child links, one link to its parent and one local port for injection and reception. Going up the tree, it waits until the local node and every child selected by a configuration mask each offer an operand word. It then combines all of them with one integer reduction operator and passes the single result on to the parent. Going down the tree, it takes a word from the parent and repeats it to every selected child and to the local node. A child port may be unused or may lead to a leaf, so the mask decides which children take part.

When the root-mode bit is set, the node is the top of the tree. The finished reduction does not go to the parent. It turns straight into a downward broadcast, which gives an all-reduce in a single pass.

Two small state machines do the work. The upward machine has the states `U_GATHER` and `U_SEND`. It takes the transition *fire* from `U_GATHER` to `U_SEND` when all inputs in use are valid in the same cycle. It takes the transition *sent* from `U_SEND` back to `U_GATHER` when the parent, or the downward path at the root, takes the result. The downward machine has the states `D_IDLE` and `D_FANOUT`. It takes the transition *take* from `D_IDLE` to `D_FANOUT` when a source word is valid and every destination in use is ready. It takes the transition *drained* from `D_FANOUT` back to `D_IDLE` when the last pending destination has completed its handshake.

Top module: `ctree_node`

## Requirements
- R1: After reset, `par_tx_valid`, `dn_ch_valid` and `rcv_valid` are all low. While no input is valid, `inj_ready` and `up_ch_ready` are low.
- R2: The result is the unsigned W-bit fold of the local word and the enabled child words. `cfg_op` selects the operator: 0 is add modulo 2^W, 1 is unsigned max, 2 is unsigned min, 3 is AND, 4 is OR and 5 is XOR.
- R3: A child takes part only if its bit in `cfg_child_en` is 1 (bit i is child i, data bits [i*W +: W]). The data of a disabled child has no effect on the result, and its `up_ch_ready` bit never rises.
- R4: A reduction fires only in a cycle where `inj_valid` is high and every enabled child is valid. In that cycle `inj_ready` and the `up_ch_ready` bits of the enabled children are high. In any other cycle they are all low.
- R5: When not in root mode, the result is offered on `par_tx_valid`/`par_tx_data` and held stable until `par_tx_ready`. No new operands are accepted while it waits.
- R6: A parent word is accepted only when `rcv_ready` is high and every enabled child is ready. The ready state of disabled children does not matter. The word is then offered to each enabled child and to the local port, and each valid drops on its own handshake.
- R7: In root mode, the finished reduction is broadcast to the enabled children and the local port as in R6. Meanwhile `par_tx_valid` and `par_rx_ready` stay low.
- R8: The reserved opcodes 6 and 7 behave as add.
- R9: The result appears on the parent port in the cycle after the fire handshake. A broadcast appears on the child and local outputs in the cycle after the source word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_root | input | 1 | Root mode: the result is broadcast down instead of sent up |
| cfg_op | input | 3 | Reduction opcode |
| cfg_child_en | input | NCH | Mask of the children that take part |
| up_ch_valid | input | NCH | Child operand valid |
| up_ch_ready | output | NCH | Child operand ready |
| up_ch_data | input | NCH*W | Child operand words |
| inj_valid | input | 1 | Local operand valid |
| inj_ready | output | 1 | Local operand ready |
| inj_data | input | W | Local operand word |
| par_tx_valid | output | 1 | Reduction result valid towards the parent |
| par_tx_ready | input | 1 | Parent accepts the result |
| par_tx_data | output | W | Reduction result |
| par_rx_valid | input | 1 | Broadcast word from the parent is valid |
| par_rx_ready | output | 1 | Broadcast word is accepted |
| par_rx_data | input | W | Broadcast word from the parent |
| dn_ch_valid | output | NCH | Broadcast valid to each child |
| dn_ch_ready | input | NCH | Child accepts the broadcast |
| dn_ch_data | output | W | Broadcast word, shared by all children |
| rcv_valid | output | 1 | Broadcast valid to the local node |
| rcv_ready | input | 1 | Local node accepts the broadcast |
| rcv_data | output | W | Broadcast word to the local node |

## Verification
The bench sweeps every opcode against every child mask, including the empty mask. Disabled children are driven valid with data that should be ignored. A design that folds in a masked child, or raises its ready, gives a wrong sum or min, or a wrong ready pattern.

A partial-valid test holds one enabled child back. A node that fires early would raise the local ready.

Broadcast tests stall either a disabled child or an enabled one. A design that waits on disabled children hangs the parent. A design that ignores enabled stalls accepts the parent word too soon. One child is also held not ready after the broadcast goes out, to show that each valid is retired separately.

Root-mode tests check that the result reaches the downward outputs one cycle after it is formed, while both parent handshakes stay quiet.

// File: rtl/ctree_pkg.sv
package ctree_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_MAX  = 3'd1,
        OP_MIN  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } red_op_e;

    typedef enum logic {U_GATHER, U_SEND} up_state_e;
    typedef enum logic {D_IDLE, D_FANOUT} dn_state_e;
endpackage

// File: rtl/ctree_combiner.sv
module ctree_combiner
    import ctree_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 3
) (
    input  red_op_e          op,
    input  logic [NCH-1:0]   en,
    input  logic [W-1:0]     loc,
    input  logic [NCH*W-1:0] ch,
    output logic [W-1:0]     res
);
    function automatic logic [W-1:0] fold2(input red_op_e o,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        logic [W-1:0] r;
        unique case (o)
            OP_MAX:  r = (a > b) ? a : b;
            OP_MIN:  r = (a < b) ? a : b;
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            default: r = a + b;   // add and the reserved codes (R8)
        endcase
        return r;
    endfunction

    logic [W-1:0] acc [NCH+1];
    assign acc[0] = loc;

    for (genvar g = 0; g < NCH; g++) begin : g_stage
        logic [W-1:0] cw;
        assign cw       = ch[g*W +: W];
        assign acc[g+1] = en[g] ? fold2(op, acc[g], cw) : acc[g];
    end

    assign res = acc[NCH];
endmodule

// File: rtl/ctree_up_fsm.sv
module ctree_up_fsm
    import ctree_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] ch_valid,
    output logic [NCH-1:0] ch_ready,
    input  logic           loc_valid,
    output logic           loc_ready,
    input  logic [W-1:0]   comb_res,
    output logic           res_valid,
    input  logic           res_ready,
    output logic [W-1:0]   res_data
);
    up_state_e state;
    logic      all_in;

    assign all_in = loc_valid && (&(ch_valid | ~en));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= U_GATHER;
            res_data <= '0;
        end else begin
            unique case (state)
                U_GATHER: if (all_in) begin       // fire
                    res_data <= comb_res;
                    state    <= U_SEND;
                end
                U_SEND: if (res_ready) begin      // sent
                    state <= U_GATHER;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state)
            U_GATHER: begin
                loc_ready = all_in;
                ch_ready  = all_in ? en : '0;
                res_valid = 1'b0;
            end
            U_SEND: begin
                loc_ready = 1'b0;
                ch_ready  = '0;
                res_valid = 1'b1;
            end
        endcase
    end

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_data)); // R5
    AST_FIRE_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid && loc_ready |-> &(ch_valid | ~en)); // R4
    AST_NO_FIRE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !loc_ready && (ch_ready == '0)); // R5
endmodule

// File: rtl/ctree_dn_fsm.sv
module ctree_dn_fsm
    import ctree_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] en,
    input  logic           src_valid,
    output logic           src_ready,
    input  logic [W-1:0]   src_data,
    output logic [NCH:0]   dst_valid,
    input  logic [NCH:0]   dst_ready,
    output logic [W-1:0]   dst_data
);
    localparam int ND = NCH + 1;

    dn_state_e     state;
    logic [ND-1:0] pend;
    logic [ND-1:0] need;
    logic [ND-1:0] left;
    logic          all_rdy;

    assign need    = {1'b1, en};
    assign all_rdy = &(dst_ready | ~need);
    assign left    = pend & ~dst_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= D_IDLE;
            pend     <= '0;
            dst_data <= '0;
        end else begin
            unique case (state)
                D_IDLE: if (src_valid && all_rdy) begin   // take
                    dst_data <= src_data;
                    pend     <= need;
                    state    <= D_FANOUT;
                end
                D_FANOUT: begin
                    pend <= left;
                    if (left == '0) state <= D_IDLE;       // drained
                end
            endcase
        end
    end

    always_comb begin
        unique case (state)
            D_IDLE: begin
                src_ready = all_rdy;
                dst_valid = '0;
            end
            D_FANOUT: begin
                src_ready = 1'b0;
                dst_valid = pend;
            end
        endcase
    end

    for (genvar k = 0; k < ND; k++) begin : g_hold
        AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            dst_valid[k] && !dst_ready[k] |=> dst_valid[k] && $stable(dst_data)); // R6
    end
endmodule

// File: rtl/ctree_node.sv
module ctree_node
    import ctree_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_root,
    input  logic [2:0]       cfg_op,
    input  logic [NCH-1:0]   cfg_child_en,
    input  logic [NCH-1:0]   up_ch_valid,
    output logic [NCH-1:0]   up_ch_ready,
    input  logic [NCH*W-1:0] up_ch_data,
    input  logic             inj_valid,
    output logic             inj_ready,
    input  logic [W-1:0]     inj_data,
    output logic             par_tx_valid,
    input  logic             par_tx_ready,
    output logic [W-1:0]     par_tx_data,
    input  logic             par_rx_valid,
    output logic             par_rx_ready,
    input  logic [W-1:0]     par_rx_data,
    output logic [NCH-1:0]   dn_ch_valid,
    input  logic [NCH-1:0]   dn_ch_ready,
    output logic [W-1:0]     dn_ch_data,
    output logic             rcv_valid,
    input  logic             rcv_ready,
    output logic [W-1:0]     rcv_data
);
    logic [W-1:0] comb_res;
    logic         up_res_valid;
    logic         up_res_ready;
    logic [W-1:0] up_res_data;
    logic         src_valid;
    logic         src_ready;
    logic [W-1:0] src_data;
    logic [NCH:0] dst_valid;
    logic [W-1:0] dst_data;

    ctree_combiner #(.W(W), .NCH(NCH)) comb_i (
        .op  (red_op_e'(cfg_op)),
        .en  (cfg_child_en),
        .loc (inj_data),
        .ch  (up_ch_data),
        .res (comb_res)
    );

    ctree_up_fsm #(.W(W), .NCH(NCH)) up_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_child_en),
        .ch_valid  (up_ch_valid),
        .ch_ready  (up_ch_ready),
        .loc_valid (inj_valid),
        .loc_ready (inj_ready),
        .comb_res  (comb_res),
        .res_valid (up_res_valid),
        .res_ready (up_res_ready),
        .res_data  (up_res_data)
    );

    assign par_tx_valid = up_res_valid && !cfg_root;
    assign par_tx_data  = up_res_data;
    assign up_res_ready = cfg_root ? src_ready : par_tx_ready;
    assign src_valid    = cfg_root ? up_res_valid : par_rx_valid;
    assign src_data     = cfg_root ? up_res_data : par_rx_data;
    assign par_rx_ready = src_ready && !cfg_root;

    ctree_dn_fsm #(.W(W), .NCH(NCH)) dn_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_child_en),
        .src_valid (src_valid),
        .src_ready (src_ready),
        .src_data  (src_data),
        .dst_valid (dst_valid),
        .dst_ready ({rcv_ready, dn_ch_ready}),
        .dst_data  (dst_data)
    );

    assign dn_ch_valid = dst_valid[NCH-1:0];
    assign rcv_valid   = dst_valid[NCH];
    assign dn_ch_data  = dst_data;
    assign rcv_data    = dst_data;

    AST_ROOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_root |-> !par_tx_valid && !par_rx_ready); // R7
    AST_PAR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        par_rx_valid && par_rx_ready |-> rcv_ready && (&(dn_ch_ready | ~cfg_child_en))); // R6
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        par_tx_valid && !par_tx_ready && !cfg_root |=> par_tx_valid && $stable(par_tx_data)); // R5
endmodule

// File: tb/ctree_node_tb_top.sv
module ctree_node_tb_top;
    localparam int W   = 8;
    localparam int NCH = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n;
    logic             cfg_root;
    logic [2:0]       cfg_op;
    logic [NCH-1:0]   cfg_child_en;
    logic [NCH-1:0]   up_ch_valid;
    logic [NCH-1:0]   up_ch_ready;
    logic [NCH*W-1:0] up_ch_data;
    logic             inj_valid;
    logic             inj_ready;
    logic [W-1:0]     inj_data;
    logic             par_tx_valid;
    logic             par_tx_ready;
    logic [W-1:0]     par_tx_data;
    logic             par_rx_valid;
    logic             par_rx_ready;
    logic [W-1:0]     par_rx_data;
    logic [NCH-1:0]   dn_ch_valid;
    logic [NCH-1:0]   dn_ch_ready;
    logic [W-1:0]     dn_ch_data;
    logic             rcv_valid;
    logic             rcv_ready;
    logic [W-1:0]     rcv_data;

    ctree_node #(.W(W), .NCH(NCH)) dut_i (.*);

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] ref_op(input int op, input logic [W-1:0] a, input logic [W-1:0] b);
        case (op)
            1: return (a > b) ? a : b;
            2: return (a < b) ? a : b;
            3: return a & b;
            4: return a | b;
            5: return a ^ b;
            default: return W'(a + b);
        endcase
    endfunction

    function automatic logic [W-1:0] ref_red(input int op, input logic [2:0] en, input logic [W-1:0] l,
                                             input logic [W-1:0] c0, input logic [W-1:0] c1,
                                             input logic [W-1:0] c2);
        logic [W-1:0] acc = l;
        if (en[0]) acc = ref_op(op, acc, c0);
        if (en[1]) acc = ref_op(op, acc, c1);
        if (en[2]) acc = ref_op(op, acc, c2);
        return acc;
    endfunction

    task automatic run_up(input int op, input logic [2:0] en, input logic [W-1:0] l,
                          input logic [W-1:0] c0, input logic [W-1:0] c1, input logic [W-1:0] c2);
        logic [W-1:0] exp = ref_red(op, en, l, c0, c1, c2);
        string rq = (op >= 6) ? "R8" : "R2";
        @(posedge clk); #1;
        cfg_root = 1'b0; cfg_op = 3'(op); cfg_child_en = en;
        up_ch_valid = 3'b111; up_ch_data = {c2, c1, c0};
        inj_valid = 1'b1; inj_data = l; par_tx_ready = 1'b0;
        #4;
        chk("R4 local ready at fire", inj_ready, 1);
        chk("R3 child readies follow mask", up_ch_ready, en);
        @(posedge clk); #5;
        chk("R9 result valid next cycle", par_tx_valid, 1);
        chk(rq, par_tx_data, exp);
        chk("R5 no accept while sending", inj_ready, 0);
        @(posedge clk); #1;
        inj_valid = 1'b0; up_ch_valid = '0; par_tx_ready = 1'b1;
        #4;
        chk("R5 result held valid", par_tx_valid, 1);
        chk("R5 result held stable", par_tx_data, exp);
        @(posedge clk); #1;
        par_tx_ready = 1'b0;
        #4;
        chk("R5 valid drops after handshake", par_tx_valid, 0);
    endtask

    task automatic run_dn(input logic [2:0] en, input logic [3:0] stall, input logic [W-1:0] d);
        logic blocked = |(stall & {1'b1, en});
        @(posedge clk); #1;
        cfg_root = 1'b0; cfg_child_en = en;
        dn_ch_ready = ~stall[2:0]; rcv_ready = ~stall[3];
        par_rx_valid = 1'b1; par_rx_data = d;
        #4;
        chk("R6 parent ready vs enabled stalls", par_rx_ready, !blocked);
        if (blocked) begin
            @(posedge clk); #5;
            chk("R6 nothing sent while stalled", {rcv_valid, dn_ch_valid}, 0);
            chk("R6 parent still held", par_rx_ready, 0);
            @(posedge clk); #1;
            dn_ch_ready = 3'b111; rcv_ready = 1'b1;
            #4;
            chk("R6 parent ready after release", par_rx_ready, 1);
        end
        @(posedge clk); #1;
        par_rx_valid = 1'b0; dn_ch_ready = 3'b110;
        #4;
        chk("R9 child valids after take", dn_ch_valid, en);
        chk("R9 local valid after take", rcv_valid, 1);
        chk("R6 child data", dn_ch_data, d);
        chk("R6 local data", rcv_data, d);
        @(posedge clk); #5;
        chk("R6 only stalled child pending", {rcv_valid, dn_ch_valid}, {1'b0, en & 3'b001});
        if (en[0]) chk("R6 pending data stable", dn_ch_data, d);
        @(posedge clk); #1;
        dn_ch_ready = 3'b111;
        @(posedge clk); #5;
        chk("R6 all drained", {rcv_valid, dn_ch_valid}, 0);
    endtask

    task automatic run_root(input int op, input logic [2:0] en, input logic [W-1:0] l,
                            input logic [W-1:0] c0, input logic [W-1:0] c1, input logic [W-1:0] c2);
        logic [W-1:0] exp = ref_red(op, en, l, c0, c1, c2);
        @(posedge clk); #1;
        cfg_root = 1'b1; cfg_op = 3'(op); cfg_child_en = en;
        dn_ch_ready = 3'b111; rcv_ready = 1'b1;
        par_rx_valid = 1'b1; par_rx_data = 8'h5A; par_tx_ready = 1'b1;
        up_ch_valid = 3'b111; up_ch_data = {c2, c1, c0}; inj_valid = 1'b1; inj_data = l;
        #4;
        chk("R4 root fire", inj_ready, 1);
        chk("R7 parent rx ignored in root", par_rx_ready, 0);
        @(posedge clk); #1;
        inj_valid = 1'b0; up_ch_valid = '0;
        #4;
        chk("R7 no parent tx in root", par_tx_valid, 0);
        chk("R7 no broadcast yet", {rcv_valid, dn_ch_valid}, 0);
        @(posedge clk); #5;
        chk("R7 children get result", dn_ch_valid, en);
        chk("R7 local gets result", rcv_valid, 1);
        chk("R7 broadcast data", rcv_data, exp);
        chk("R7 child data", dn_ch_data, exp);
        chk("R7 parent tx still quiet", par_tx_valid, 0);
        @(posedge clk); #5;
        chk("R7 broadcast drained", {rcv_valid, dn_ch_valid}, 0);
        @(posedge clk); #1;
        par_rx_valid = 1'b0; cfg_root = 1'b0; par_tx_ready = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_root = 1'b0; cfg_op = '0; cfg_child_en = '0;
        up_ch_valid = '0; up_ch_data = '0; inj_valid = 1'b0; inj_data = '0;
        par_tx_ready = 1'b0; par_rx_valid = 1'b0; par_rx_data = '0;
        dn_ch_ready = '0; rcv_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #4;
        chk("R1 tx valid after reset", par_tx_valid, 0);
        chk("R1 down valids after reset", {rcv_valid, dn_ch_valid}, 0);
        chk("R1 readies idle", {inj_ready, up_ch_ready}, 0);

        // R2 R3 R8 R9: sweep of opcodes, masks and data patterns
        for (int op = 0; op < 8; op++)
            for (int en = 0; en < 8; en++)
                for (int s = 0; s < 3; s++) begin
                    logic [W-1:0] v[4];
                    for (int i = 0; i < 4; i++)
                        v[i] = (s == 2) ? W'(8'hC0 + i * 37) : W'(s * 61 + op * 17 + en * 7 + i * 45 + 3);
                    run_up(op, 3'(en), v[3], v[0], v[1], v[2]);
                end

        // R4: one enabled child withheld, then local withheld
        @(posedge clk); #1;
        cfg_op = 3'd0; cfg_child_en = 3'b111; up_ch_valid = 3'b011;
        up_ch_data = {8'd3, 8'd2, 8'd1}; inj_valid = 1'b1; inj_data = 8'd10;
        for (int k = 0; k < 3; k++) begin
            #4;
            chk("R4 no fire on partial valid", {inj_ready, up_ch_ready}, 0);
            chk("R4 nothing sent", par_tx_valid, 0);
            @(posedge clk); #1;
        end
        up_ch_valid = 3'b111; inj_valid = 1'b0;
        #4;
        chk("R4 no fire without local", {inj_ready, up_ch_ready}, 0);
        @(posedge clk); #1;
        up_ch_valid = '0;
        run_up(0, 3'b111, 8'd10, 8'd1, 8'd2, 8'd3);

        // R6 R9: broadcast masks and stall patterns
        for (int en = 0; en < 8; en++)
            for (int p = 0; p < 4; p++) begin
                logic [3:0] st = (p == 0) ? 4'b0000 : (p == 1) ? 4'b0001 : (p == 2) ? 4'b0100 : 4'b1000;
                run_dn(3'(en), st, W'(en * 29 + p * 3 + 1));
            end

        // R7: root mode all-reduce
        for (int op = 0; op < 8; op++) begin
            run_root(op, 3'b111, W'(op * 11 + 5), 8'hF3, 8'h2C, 8'h81);
            run_root(op, 3'b101, W'(op * 7 + 9), 8'h0F, 8'hEE, 8'h70);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule